// File: doc/BRIEF.md
# Shared-Bus Arbiter with Atomic Hold

This block decides which of N processors owns a synchronously clocked shared bus. Every processor drives its own request line. The arbiter keeps one shared busy flag. A processor can win only while the bus is free, and only when it is the most favoured of all processors that are requesting in that cycle. The winner is registered on the next clock edge. From that edge on, busy stays high and the one-hot grant stays fixed until the owner finishes its transfer.

An owner normally releases the bus once its single access is done, by dropping its request. A shared hold input lets the owner keep the bus across an atomic read-modify-write. While hold is high, ownership does not change, even if the owner's request goes low between the read and the write. Priority can be fixed, where the lowest index wins. It can also rotate, where the most recently granted processor becomes the least favoured. A mode input selects between the two.

Top module: `lockbus_arbiter`

## Requirements
- R1: An asserted reset, which acts at once, clears grant and busy. After reset the rotation start point is processor 0, so the first rotating arbitration with all requests high grants processor 0.
- R2: While the bus is free and at least one request is high, the next clock edge sets busy to 1 and grants exactly one requesting processor.
- R3: With rotate_i = 0, the lowest request index always wins. Grant bit k belongs to request bit k.
- R4: While busy is 1 and the owner keeps its request high, the grant does not change, even if a more favoured processor requests.
- R5: When the owner's request is low and hold_i is low, the next edge clears busy and grant. Arbitration runs in that free cycle, and the new winner is registered on the edge after it.
- R6: While busy is 1 and hold_i is 1, the owner keeps the bus even if its own request is low.
- R7: hold_i has no effect while the bus is free. It grants nothing when no request is high, and it does not change which processor wins.
- R8: With rotate_i = 1, the search starts one index above the processor granted most recently (in either mode) and wraps from N-1 to 0. The most recently granted processor is therefore the least favoured.
- R9: The grant is always one-hot or zero, and busy is 1 exactly when a grant bit is set.
- R10: With no request high and the bus free, busy and grant stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rotate_i | input | 1 | 1 selects rotating priority, 0 selects fixed priority (index 0 highest) |
| hold_i | input | 1 | Keeps the current owner on the bus across an atomic sequence |
| req_i | input | N | One request line per processor |
| grant_o | output | N | Registered one-hot grant |
| busy_o | output | 1 | Registered busy flag, high while an owner holds the bus |

## Verification
The assertions assume that all inputs are synchronous to clk_i and settle away from its rising edge. They do not assume that a requester keeps its request until it wins, or that hold_i is raised only by the owner. The bench changes inputs only on falling edges. It also raises hold_i both while the bus is free and while it is owned, so the properties are exercised on both sides of that assumption.

// File: rtl/lockbus_pkg.sv
package lockbus_pkg;

  typedef enum logic {
    PRIO_FIXED  = 1'b0,
    PRIO_ROTATE = 1'b1
  } prio_mode_e;

endpackage

// File: rtl/lockbus_rst_sync.sv
module lockbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/lockbus_pick.sv
module lockbus_pick #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] start_i,
  output logic [N-1:0]     pick_o,
  output logic [IDX_W-1:0] pick_idx_o,
  output logic             any_o
);

  logic             found;
  logic [IDX_W-1:0] win_idx;

  // Walk the ring from start_i; the first active request wins.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int k = 0; k < N; k++) begin
      int pos;
      pos = int'(start_i) + k;
      if (pos >= N) pos = pos - N;
      if (!found && req_i[pos]) begin
        found   = 1'b1;
        win_idx = IDX_W'(pos);
      end
    end
  end

  always_comb begin
    pick_o          = '0;
    pick_o[win_idx] = found;
  end

  assign pick_idx_o = win_idx;
  assign any_o      = found;

endmodule

// File: rtl/lockbus_rotor.sv
module lockbus_rotor #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_i,
  input  logic [IDX_W-1:0] win_idx_i,
  output logic [IDX_W-1:0] ptr_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic             ptr_en;

  assign ptr_en = win_i;

  always_comb begin
    if (win_idx_i == LAST_IDX) ptr_d = '0;
    else                       ptr_d = win_idx_i + IDX_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/lockbus_owner.sv
module lockbus_owner #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         hold_i,
  input  logic [N-1:0] pick_i,
  input  logic         any_i,
  output logic [N-1:0] grant_o,
  output logic         busy_o,
  output logic         win_o
);

  logic [N-1:0] grant_q, grant_d;
  logic         busy_q, busy_d;
  logic         owner_req;
  logic         release_now;
  logic         state_en;

  assign owner_req   = |(grant_q & req_i);
  assign release_now = busy_q && !owner_req && !hold_i;
  assign win_o       = !busy_q && any_i;
  assign state_en    = !busy_q || release_now;

  always_comb begin
    grant_d = grant_q;
    busy_d  = busy_q;
    if (busy_q) begin
      if (release_now) begin
        grant_d = '0;
        busy_d  = 1'b0;
      end
    end else begin
      grant_d = any_i ? pick_i : '0;
      busy_d  = any_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      busy_q  <= 1'b0;
    end else if (state_en) begin
      grant_q <= grant_d;
      busy_q  <= busy_d;
    end
  end

  assign grant_o = grant_q;
  assign busy_o  = busy_q;

  // R9
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_q) && (busy_q == (grant_q != '0)));

  // R2
  free_req_claims_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && (req_i != '0)) |=> busy_q);

  // R2
  grant_to_requester_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> ((grant_q & $past(req_i)) != '0));

  // R4
  owner_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ((grant_q & req_i) != '0)) |=> (busy_q && $stable(grant_q)));

  // R6
  hold_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && hold_i) |=> (busy_q && $stable(grant_q)));

  // R5
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ((grant_q & req_i) == '0) && !hold_i) |=> !busy_q);

  // R10
  idle_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && (req_i == '0)) |=> (!busy_q && (grant_q == '0)));

endmodule

// File: rtl/lockbus_arbiter.sv
module lockbus_arbiter
  import lockbus_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rotate_i,
  input  logic         hold_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         busy_o
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  prio_mode_e       mode;
  logic             rst_n;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] start;
  logic [N-1:0]     pick;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any;
  logic             win;

  assign mode  = prio_mode_e'(rotate_i);
  assign start = (mode == PRIO_ROTATE) ? ptr : '0;

  lockbus_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  lockbus_pick #(.N(N), .IDX_W(IDX_W)) i_pick (
    .req_i      (req_i),
    .start_i    (start),
    .pick_o     (pick),
    .pick_idx_o (pick_idx),
    .any_o      (pick_any)
  );

  lockbus_rotor #(.N(N), .IDX_W(IDX_W)) i_rotor (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .win_i     (win),
    .win_idx_i (pick_idx),
    .ptr_o     (ptr)
  );

  lockbus_owner #(.N(N)) i_owner (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .req_i   (req_i),
    .hold_i  (hold_i),
    .pick_i  (pick),
    .any_i   (pick_any),
    .grant_o (grant_o),
    .busy_o  (busy_o),
    .win_o   (win)
  );

  // R3
  fixed_lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_o && !rotate_i && req_i[0]) |=> grant_o[0]);

endmodule

// File: tb/test_lockbus_arbiter.sv
module test_lockbus_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int NVEC       = 25;

  logic         clk;
  logic         rst_ni;
  logic         rotate;
  logic         hold;
  logic [N-1:0] req;
  logic [N-1:0] grant;
  logic         busy;

  int checks;
  int errors;
  bit done;

  lockbus_arbiter #(.N(N)) i_lockbus_arbiter (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .rotate_i (rotate),
    .hold_i   (hold),
    .req_i    (req),
    .grant_o  (grant),
    .busy_o   (busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // {rotate, hold, req[3:0], expected grant[3:0], expected busy}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0},
    {1'b0, 1'b0, 4'b1010, 4'b0010, 1'b1},
    {1'b0, 1'b0, 4'b1011, 4'b0010, 1'b1},
    {1'b0, 1'b0, 4'b1001, 4'b0000, 1'b0},
    {1'b0, 1'b0, 4'b1001, 4'b0001, 1'b1},
    {1'b0, 1'b1, 4'b1000, 4'b0001, 1'b1},
    {1'b0, 1'b1, 4'b1000, 4'b0001, 1'b1},
    {1'b0, 1'b0, 4'b1000, 4'b0000, 1'b0},
    {1'b0, 1'b0, 4'b1000, 4'b1000, 1'b1},
    {1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0},
    {1'b0, 1'b1, 4'b0000, 4'b0000, 1'b0},
    {1'b0, 1'b1, 4'b0100, 4'b0100, 1'b1},
    {1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0},
    {1'b1, 1'b0, 4'b1111, 4'b1000, 1'b1},
    {1'b1, 1'b0, 4'b0111, 4'b0000, 1'b0},
    {1'b1, 1'b0, 4'b1111, 4'b0001, 1'b1},
    {1'b1, 1'b0, 4'b1110, 4'b0000, 1'b0},
    {1'b1, 1'b0, 4'b1111, 4'b0010, 1'b1},
    {1'b1, 1'b0, 4'b1101, 4'b0000, 1'b0},
    {1'b1, 1'b0, 4'b1101, 4'b0100, 1'b1},
    {1'b1, 1'b0, 4'b1001, 4'b0000, 1'b0},
    {1'b1, 1'b0, 4'b0011, 4'b0001, 1'b1},
    {1'b1, 1'b0, 4'b0010, 4'b0000, 1'b0},
    {1'b1, 1'b0, 4'b0010, 4'b0010, 1'b1},
    {1'b1, 1'b0, 4'b0000, 4'b0000, 1'b0}
  };

  localparam int TAG [NVEC] = '{10, 3, 4, 5, 3, 6, 6, 5, 2, 5, 7, 7, 5,
                                8, 5, 8, 5, 8, 5, 8, 5, 8, 5, 2, 9};

  function automatic string tag_name(int t);
    case (t)
      1:       return "R1";
      2:       return "R2";
      3:       return "R3";
      4:       return "R4";
      5:       return "R5";
      6:       return "R6";
      7:       return "R7";
      8:       return "R8";
      9:       return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [N-1:0] exp_g, logic exp_b);
    checks++;
    if (grant !== exp_g || busy !== exp_b) begin
      errors++;
      $display("FAIL %s: grant=%b busy=%b expected grant=%b busy=%b",
               tag, grant, busy, exp_g, exp_b);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_ni = 1'b0;
    rotate = 1'b0;
    hold   = 1'b0;
    req    = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle after reset
    check("R1", 4'b0000, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      rotate = VEC[i][10];
      hold   = VEC[i][9];
      req    = VEC[i][8:5];
      @(negedge clk);
      check(tag_name(TAG[i]), VEC[i][4:1], VEC[i][0]);
    end

    // R2: single requester on a free bus, rotating mode
    req = 4'b0100;
    @(negedge clk);
    check("R2", 4'b0100, 1'b1);

    // R1: asynchronous clear in the middle of a transfer
    req = 4'b1111;
    #1 rst_ni = 1'b0;
    #1 check("R1", 4'b0000, 1'b0);
    @(negedge clk);
    check("R1", 4'b0000, 1'b0);
    req    = '0;
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 4'b0000, 1'b0);

    // R1: rotation start is processor 0 after reset
    rotate = 1'b1;
    req    = 4'b1111;
    @(negedge clk);
    check("R1", 4'b0001, 1'b1);

    // R4: higher-index pressure does not move the owner
    @(negedge clk);
    check("R4", 4'b0001, 1'b1);

    // R6 then R5: hold across the gap, then release
    req  = 4'b1110;
    hold = 1'b1;
    @(negedge clk);
    check("R6", 4'b0001, 1'b1);
    hold = 1'b0;
    @(negedge clk);
    check("R5", 4'b0000, 1'b0);
    @(negedge clk);
    check("R8", 4'b0010, 1'b1);

    req = '0;
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule